// File: doc/BRIEF.md
# Warp Segment Coalescer

This block takes one warp memory instruction (one byte address per lane, an active-lane mask and a single access size) and turns it into the smallest set of bus transactions. Each transaction covers one aligned 32-byte segment. Transactions leave one at a time on a valid/ready output, lowest segment address first. Each one carries a bitmask of the lanes it serves, so a segment shared by many lanes (including a full broadcast of one word) is fetched only once.

The block also keeps two running byte totals. One counts the bytes the lanes asked for and the other counts the bytes moved on the bus, so bus utilization can be worked out from their ratio. A clear input zeroes both totals.

The controller has two states. In `ST_IDLE` it accepts a request. It moves to `ST_ISSUE` when the accepted mask is non-empty. If the mask is empty it stays in `ST_IDLE`. In `ST_ISSUE` it presents the lowest segment that still has unserved lanes. It returns to `ST_IDLE` on the handshake that serves the last pending lanes. Otherwise it stays in `ST_ISSUE` and moves on to the next segment.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0, and both byte totals are 0.
- R2: An active lane with address A is served by the segment whose address is A with its low 5 bits cleared. The block emits exactly one transaction for each distinct segment that the active lanes touch.
- R3: Within one request, transactions are emitted in strictly ascending segment address order.
- R4: `txn_lanes` of a transaction holds exactly the active lanes whose addresses fall in that segment, with bit i standing for lane i. Every active lane appears in exactly one transaction.
- R5: Lanes whose mask bit is 0 add no segments and no requested bytes. A request with an all-zero mask produces no transaction, and `req_ready` is 1 again in the following cycle.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_seg` and `txn_lanes` hold their values.
- R7: `req_ready` is 0 while any transaction of the current request is outstanding. It returns to 1 in the cycle after the last transaction's handshake.
- R8: `req_size` codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes. Accepting a request adds (number of active lanes) × (size) to `bytes_req`.
- R9: Each transaction handshake adds 32 to `bytes_moved`.
- R10: `stats_clr` zeroes both totals. If an accounting event falls in the same cycle as the clear, the affected total takes only that event's amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | LANES*ADDR_W | Lane byte addresses; lane i in bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 3 | Access size code (log2 of bytes) |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_seg | output | ADDR_W | Aligned segment byte address |
| txn_lanes | output | LANES | Lanes served by this segment |
| stats_clr | input | 1 | Clear both byte totals |
| bytes_req | output | CNT_W | Total bytes requested by active lanes |
| bytes_moved | output | CNT_W | Total bytes moved by transactions |

## Verification
A clear of the totals can land in the same cycle as an accounting event. For `bytes_req` that event is a request acceptance, and for `bytes_moved` it is a transaction handshake. The bench provokes both cases. It raises `stats_clr` together with `req_valid`, and then again on the first transaction handshake of that request. After each edge it expects the affected total to equal exactly that event's contribution (128 bytes requested, then 32 bytes moved) and the other total to be zero.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

    // Access size code (log2 bytes) to byte count; codes above 4 saturate at 16.
    function automatic logic [4:0] size_bytes(input logic [2:0] code);
        if (code > 3'd4) return 5'd16;
        return 5'd1 << code;
    endfunction
endpackage

// File: rtl/coal_seg_min.sv
module coal_seg_min #(
    parameter int LANES = 32,
    parameter int SEG_W = 27
) (
    input  logic [LANES*SEG_W-1:0] seg_flat,
    input  logic [LANES-1:0]       pend,
    output logic [SEG_W-1:0]       min_seg,
    output logic [LANES-1:0]       hit
);
    always_comb begin
        logic found;
        found   = 1'b0;
        min_seg = '1;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && (!found || seg_flat[i*SEG_W +: SEG_W] < min_seg)) begin
                min_seg = seg_flat[i*SEG_W +: SEG_W];
                found   = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_hit
        assign hit[g] = pend[g] && (seg_flat[g*SEG_W +: SEG_W] == min_seg);
    end
endmodule

// File: rtl/coal_stats.sv
module coal_stats #(
    parameter int CNT_W     = 32,
    parameter int ACC_W     = 10,
    parameter int SEG_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc_en,
    input  logic [ACC_W-1:0] acc_bytes,
    input  logic             mov_en,
    output logic [CNT_W-1:0] bytes_req,
    output logic [CNT_W-1:0] bytes_mov
);
    localparam logic [CNT_W-1:0] SEG_INC = CNT_W'(SEG_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_req <= '0;
            bytes_mov <= '0;
        end else if (clr) begin
            bytes_req <= acc_en ? CNT_W'(acc_bytes) : '0;
            bytes_mov <= mov_en ? SEG_INC : '0;
        end else begin
            if (acc_en) bytes_req <= bytes_req + CNT_W'(acc_bytes);
            if (mov_en) bytes_mov <= bytes_mov + SEG_INC;
        end
    end

    a_r9_move_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_en && !clr) |=> bytes_mov == $past(bytes_mov) + SEG_INC);

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !acc_en && !mov_en) |=> (bytes_req == '0 && bytes_mov == '0));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 32,
    parameter int CNT_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic [2:0]              req_size,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_seg,
    output logic [LANES-1:0]        txn_lanes,
    input  logic                    stats_clr,
    output logic [CNT_W-1:0]        bytes_req,
    output logic [CNT_W-1:0]        bytes_moved
);
    localparam int OFF_W = $clog2(SEG_BYTES);
    localparam int SEG_W = ADDR_W - OFF_W;
    localparam int ACC_W = $clog2(LANES * 16 + 1);

    coal_state_e              state_q, state_d;
    logic [LANES*SEG_W-1:0]   seg_q;
    logic [LANES-1:0]         pend_q;
    logic [SEG_W-1:0]         min_seg;
    logic [LANES-1:0]         hit;
    logic [ACC_W-1:0]         acc_bytes;
    logic                     accept, handoff;

    assign accept  = req_valid && req_ready;
    assign handoff = txn_valid && txn_ready;

    // Output process
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: txn_valid = 1'b1;
            default:  ;
        endcase
    end

    assign txn_seg   = {min_seg, {OFF_W{1'b0}}};
    assign txn_lanes = hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && req_mask != '0) state_d = ST_ISSUE;
            ST_ISSUE: if (handoff && (pend_q & ~hit) == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            seg_q  <= '0;
        end else if (accept) begin
            pend_q <= req_mask;
            for (int i = 0; i < LANES; i++)
                seg_q[i*SEG_W +: SEG_W] <= req_addr[i*ADDR_W + OFF_W +: SEG_W];
        end else if (handoff) begin
            pend_q <= pend_q & ~hit;
        end
    end

    always_comb begin
        acc_bytes = '0;
        for (int i = 0; i < LANES; i++)
            if (req_mask[i]) acc_bytes = acc_bytes + ACC_W'(size_bytes(req_size));
    end

    coal_seg_min #(.LANES(LANES), .SEG_W(SEG_W)) u_min (
        .seg_flat (seg_q),
        .pend     (pend_q),
        .min_seg  (min_seg),
        .hit      (hit)
    );

    coal_stats #(.CNT_W(CNT_W), .ACC_W(ACC_W), .SEG_BYTES(SEG_BYTES)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (stats_clr),
        .acc_en    (accept),
        .acc_bytes (acc_bytes),
        .mov_en    (handoff),
        .bytes_req (bytes_req),
        .bytes_mov (bytes_moved)
    );

    a_r4_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_lanes != '0);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_seg) && $stable(txn_lanes)));

    a_r3_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && $past(txn_valid && txn_ready)) |-> txn_seg > $past(txn_seg));

    a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> req_ready);

    a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> (txn_lanes & $past(txn_lanes)) == '0);
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
    localparam int L  = 32;
    localparam int AW = 32;
    localparam int NV = 8;

    localparam logic [31:0] V_BASE   [NV] = '{32'h0, 32'h4, 32'h40, 32'h0,
                                              32'h0, 32'h1000, 32'h2000, 32'h300};
    localparam logic [31:0] V_STRIDE [NV] = '{32'd4, 32'd4, 32'd0, 32'd12,
                                              32'd16, 32'd1, 32'hFFFF_FFE0, 32'd4};
    localparam logic [2:0]  V_SIZE   [NV] = '{3'd2, 3'd2, 3'd2, 3'd2,
                                              3'd4, 3'd0, 3'd3, 3'd2};
    localparam logic [31:0] V_MASK   [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                              32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF,
                                              32'hFFFF_FFFF, 32'h0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, txn_ready = 1'b0, stats_clr = 1'b0;
    logic [L*AW-1:0] req_addr = '0;
    logic [L-1:0] req_mask = '0;
    logic [2:0] req_size = '0;
    logic req_ready, txn_valid;
    logic [AW-1:0] txn_seg;
    logic [L-1:0] txn_lanes;
    logic [31:0] bytes_req, bytes_moved;

    int errors = 0, checks = 0;
    logic done = 1'b0;
    logic [31:0] exp_req = 0, exp_mov = 0;
    logic [31:0] es [L];
    logic [31:0] el [L];
    int ne;

    always #4 clk = ~clk;

    warp_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_seg(txn_seg),
        .txn_lanes(txn_lanes), .stats_clr(stats_clr), .bytes_req(bytes_req),
        .bytes_moved(bytes_moved)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: sorted unique segment list with lane bitmaps
    task automatic build_expect(input logic [31:0] base, input logic [31:0] stride, input logic [31:0] mask);
        ne = 0;
        for (int i = 0; i < L; i++) begin
            if (mask[i]) begin
                logic [31:0] s;
                int pos;
                logic found;
                s = (base + i * stride) & 32'hFFFF_FFE0;
                found = 1'b0;
                for (int j = 0; j < ne; j++)
                    if (es[j] == s) begin el[j][i] = 1'b1; found = 1'b1; end
                if (!found) begin
                    pos = ne;
                    for (int j = ne - 1; j >= 0; j--)
                        if (es[j] > s) pos = j;
                    for (int j = ne; j > pos; j--) begin es[j] = es[j-1]; el[j] = el[j-1]; end
                    es[pos] = s;
                    el[pos] = 32'h0;
                    el[pos][i] = 1'b1;
                    ne++;
                end
            end
        end
    endtask

    task automatic run_vec(input int v);
        int got, guard;
        logic stall;
        logic [31:0] hs, hl;
        build_expect(V_BASE[v], V_STRIDE[v], V_MASK[v]);
        @(negedge clk);
        check(req_ready == 1'b1, "R7 ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1;
        req_mask = V_MASK[v];
        req_size = V_SIZE[v];
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = V_BASE[v] + i * V_STRIDE[v];
        exp_req += 32'($countones(V_MASK[v])) * (32'h1 << V_SIZE[v]);
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; guard = 0; stall = 1'b0; hs = 0; hl = 0;
        while (got < ne && guard < 400) begin
            txn_ready = (guard % 3) != 2;
            if (stall)
                check(txn_valid && txn_seg == hs && txn_lanes == hl, "R6 hold while stalled", txn_seg, hs);
            if (txn_valid) begin
                check(req_ready == 1'b0, "R7 ready low while issuing", 32'(req_ready), 32'h0);
                if (txn_ready) begin
                    check(txn_seg == es[got], "R2 R3 segment address/order", txn_seg, es[got]);
                    check(txn_lanes == el[got], "R4 lane set", txn_lanes, el[got]);
                    got++;
                    exp_mov += 32;
                end
                stall = !txn_ready;
                hs = txn_seg;
                hl = txn_lanes;
            end else stall = 1'b0;
            @(negedge clk);
            guard++;
        end
        txn_ready = 1'b0;
        check(got == ne, "R2 transaction count", 32'(got), 32'(ne));
        check(!txn_valid && req_ready, "R7 R5 idle after last", {30'h0, txn_valid, req_ready}, 32'h1);
        check(bytes_req == exp_req, "R8 requested bytes", bytes_req, exp_req);
        check(bytes_moved == exp_mov, "R9 moved bytes", bytes_moved, exp_mov);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
        check(txn_valid == 1'b0, "R1 reset txn_valid", 32'(txn_valid), 32'h0);
        check(bytes_req == 0 && bytes_moved == 0, "R1 reset totals", bytes_req | bytes_moved, 32'h0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R10: clear coinciding with acceptance, then with a handshake
        @(negedge clk);
        stats_clr = 1'b1;
        req_valid = 1'b1;
        req_mask = 32'hFFFF_FFFF;
        req_size = 3'd2;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = 32'h800 + i * 4;
        @(negedge clk);
        stats_clr = 1'b0;
        req_valid = 1'b0;
        check(bytes_req == 32'd128, "R10 clear with accept (req)", bytes_req, 32'd128);
        check(bytes_moved == 32'd0, "R10 clear with accept (moved)", bytes_moved, 32'd0);
        check(txn_valid == 1'b1, "R7 issuing after accept", 32'(txn_valid), 32'h1);
        txn_ready = 1'b1;
        stats_clr = 1'b1;
        @(negedge clk);
        stats_clr = 1'b0;
        check(bytes_moved == 32'd32, "R10 clear with handshake (moved)", bytes_moved, 32'd32);
        check(bytes_req == 32'd0, "R10 clear with handshake (req)", bytes_req, 32'd0);
        check(req_ready == 1'b0, "R7 busy mid request", 32'(req_ready), 32'h0);
        repeat (3) @(negedge clk);
        txn_ready = 1'b0;
        check(bytes_moved == 32'd128, "R9 drain after clear", bytes_moved, 32'd128);
        check(req_ready == 1'b1 && !txn_valid, "R7 ready after drain", 32'(req_ready), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule